// File: doc/BRIEF.md
# VRAM Time-Slot CPU Access Arbiter

This block sits between a host CPU and the two halves (A and B) of a video RAM. The display engine cuts each access cycle into eight time slots. For each slot and each bank, a programmable pattern word holds a 4-bit command. The block reads the current slot number from the display timing and decodes the commands for both halves. It also looks at the per-layer display enables and the bank-split flags. From these it decides, in the same cycle, whether the CPU may use that slot on each half. CPU access is granted to a half as a whole, never to one bank alone.

CPU writes enter a two-entry write buffer, so short bursts complete without stalling. The buffer drains in FIFO order, one entry per cycle, into slots that are legal for the entry's half. A read is issued only when its half has a legal slot and no buffered write to that half is still pending. When a request cannot be taken in the current cycle, the CPU wait output is raised.

Top module: `vram_slot_arbiter`

## Requirements
- R1: With a half unsplit and display active, a slot whose bank 0 command nibble (bits 4k+3:4k of the bank 0 pattern for slot k) is 0xC (CPU) or 0xF (idle) is a CPU slot.
- R2: With a half unsplit and display active, a slot holding a layer fetch code 0x0–0x7 is a CPU slot exactly when `layer_en` bit for that code is 0. Codes 0x8–0xB, 0xD and 0xE never give a CPU slot.
- R3: With a half split and display active, slot k is a CPU slot only if both bank patterns hold 0xC at k. In addition, slot k−1 (mod 8) must either hold 0xF in both banks or itself be a CPU slot under this rule. A ring made only of 0xC slots therefore gives no CPU slot.
- R4: With `display_active` low, every slot is a CPU slot on both halves, whatever the patterns, enables and split flags.
- R5: `slot_ok_a`/`slot_ok_b` reflect the slot named by `slot_idx` in the same cycle, with no register on the way.
- R6: A write (`cpu_we`=1, `cpu_half` 0=A, 1=B) is taken without wait when the buffer holds fewer than two entries, or when its head drains in that cycle. Buffered writes reach the RAM strobes in arrival order, one per cycle, in a CPU slot of their half, at the earliest one cycle after acceptance.
- R7: A write arriving with the buffer full and no drain in that cycle raises `cpu_wait` and is not taken.
- R8: A read is issued (strobe with `we`=0 and the CPU address) in the cycle its half has a CPU slot and no buffered write to that half. Otherwise `cpu_wait` is high.
- R9: A RAM strobe of a half is raised only in a CPU slot of that half.
- R10: While `rst_n` is low, the buffer is emptied, no strobe is raised and `cpu_wait` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| display_active | input | 1 | High in active display, low in blanking |
| slot_idx | input | 3 | Current time slot number |
| layer_en | input | 8 | Display enable per screen layer |
| split_a | input | 1 | Half A split into two banks |
| split_b | input | 1 | Half B split into two banks |
| pat_a_bk0 | input | 32 | Half A bank 0 slot commands, nibble per slot |
| pat_a_bk1 | input | 32 | Half A bank 1 slot commands |
| pat_b_bk0 | input | 32 | Half B bank 0 slot commands |
| pat_b_bk1 | input | 32 | Half B bank 1 slot commands |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_half | input | 1 | Target half, 0=A 1=B |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 32 | CPU write data (two words) |
| cpu_wait | output | 1 | Request not taken this cycle |
| slot_ok_a | output | 1 | Current slot usable by CPU on half A |
| slot_ok_b | output | 1 | Current slot usable by CPU on half B |
| ram_a_en | output | 1 | Half A access strobe |
| ram_a_we | output | 1 | Half A write enable |
| ram_a_addr | output | 16 | Half A address |
| ram_a_wdata | output | 32 | Half A write data |
| ram_b_en | output | 1 | Half B access strobe |
| ram_b_we | output | 1 | Half B write enable |
| ram_b_addr | output | 16 | Half B address |
| ram_b_wdata | output | 32 | Half B write data |

## Verification
The slot qualifiers, `cpu_wait` and the RAM strobes are all due in the cycle in which their inputs are presented. They are combinational functions of the inputs and of the buffer contents. Buffer contents change only at the rising edge after a write is taken or an entry drains, so a write can reach a strobe one cycle after acceptance at the earliest. The bench therefore sets inputs just after a rising edge and compares every output at the following falling edge. Only after that comparison does it advance its reference queue, so each compare sees the same buffer state as the design.

// File: rtl/vslot_pkg.sv
package vslot_pkg;
   localparam int unsigned CMD_W      = 4;
   localparam int unsigned MAX_LAYERS = 8;
   localparam logic [CMD_W-1:0] CMD_CPU  = 4'hC;
   localparam logic [CMD_W-1:0] CMD_IDLE = 4'hF;
endpackage

// File: rtl/vslot_qualify.sv
module vslot_qualify
   import vslot_pkg::*;
#(
   parameter int unsigned NSLOT     = 8,
   parameter int unsigned NLAYER    = 8,
   parameter bit          SPLIT_CAP = 1'b1,
   localparam int unsigned SW       = $clog2(NSLOT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    display_active,
   input  logic                    split_en,
   input  logic [NLAYER-1:0]       layer_en,
   input  logic [NSLOT*CMD_W-1:0]  pat_bk0,
   input  logic [NSLOT*CMD_W-1:0]  pat_bk1,
   input  logic [SW-1:0]           slot_idx,
   output logic                    slot_ok
);
   localparam int unsigned NCODE = 1 << CMD_W;

   logic [CMD_W-1:0] cmd0 [NSLOT];
   logic [CMD_W-1:0] cmd1 [NSLOT];
   logic [NSLOT-1:0] both_cpu, both_idle, solo_ok, chain_ok, slot_mask;
   logic [NCODE-1:0] fetch_off;
   logic [CMD_W-1:0] cur0, cur1;

   // layer fetch codes whose layer is disabled free up the slot
   for (genvar gc = 0; gc < NCODE; gc++) begin : g_fetch
      if (gc < NLAYER) begin : g_layer
         assign fetch_off[gc] = ~layer_en[gc];
      end else begin : g_none
         assign fetch_off[gc] = 1'b0;
      end
   end

   for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
      assign cmd0[gs]      = pat_bk0[gs*CMD_W +: CMD_W];
      assign cmd1[gs]      = pat_bk1[gs*CMD_W +: CMD_W];
      assign both_cpu[gs]  = (cmd0[gs] == CMD_CPU)  && (cmd1[gs] == CMD_CPU);
      assign both_idle[gs] = (cmd0[gs] == CMD_IDLE) && (cmd1[gs] == CMD_IDLE);
      assign solo_ok[gs]   = (cmd0[gs] == CMD_CPU) || (cmd0[gs] == CMD_IDLE)
                             || fetch_off[cmd0[gs]];
   end

   if (SPLIT_CAP) begin : g_split
      logic [NSLOT-1:0] idle_prev;
      assign idle_prev = {both_idle[NSLOT-2:0], both_idle[NSLOT-1]};
      // least fixpoint over the slot ring: a run must start after an idle pair
      always_comb begin : chain
         logic [NSLOT-1:0] run;
         run = '0;
         for (int it = 0; it < NSLOT; it++) begin
            run = both_cpu & (idle_prev | {run[NSLOT-2:0], run[NSLOT-1]});
         end
         chain_ok = run;
      end
      assign slot_mask = !display_active ? '1 : (split_en ? chain_ok : solo_ok);
   end else begin : g_nosplit
      assign chain_ok  = '0;
      assign slot_mask = !display_active ? '1 : solo_ok;
   end

   assign slot_ok = slot_mask[slot_idx];
   assign cur0    = cmd0[slot_idx];
   assign cur1    = cmd1[slot_idx];

   assert_cpu_or_idle_open_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      display_active && !split_en && (cur0 == CMD_CPU || cur0 == CMD_IDLE) |-> slot_ok);

   assert_split_both_cpu_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      display_active && split_en && slot_ok |-> (cur0 == CMD_CPU) && (cur1 == CMD_CPU));

   assert_blank_open_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !display_active |-> slot_ok);
endmodule

// File: rtl/vslot_wbuf.sv
module vslot_wbuf #(
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned EW     = 49,
   parameter int unsigned KEYPOS = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] push_data,
   input  logic          pop,
   output logic [EW-1:0] head,
   output logic          full,
   output logic          empty,
   output logic [1:0]    key_seen
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [EW-1:0]    store [DEPTH];
   logic [DEPTH-1:0] valid;
   logic [PW-1:0]    rd_ptr, wr_ptr;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      if (p == PW'(DEPTH-1)) return '0;
      return p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= '0;
         rd_ptr <= '0;
         wr_ptr <= '0;
      end else begin
         if (pop) begin
            valid[rd_ptr] <= 1'b0;
            rd_ptr        <= bump(rd_ptr);
         end
         if (push) begin
            valid[wr_ptr] <= 1'b1;
            wr_ptr        <= bump(wr_ptr);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= push_data;
   end

   assign head  = store[rd_ptr];
   assign full  = &valid;
   assign empty = ~|valid;

   always_comb begin
      key_seen = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (valid[i]) key_seen[store[i][KEYPOS]] = 1'b1;
      end
   end

   assert_no_overflow_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));

   assert_no_underflow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
   import vslot_pkg::*;
#(
   parameter int unsigned NSLOT     = 8,
   parameter int unsigned NLAYER    = 8,
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 32,
   parameter int unsigned WB_DEPTH  = 2,
   parameter logic [1:0]  SPLIT_CAP = 2'b11,
   localparam int unsigned SW       = $clog2(NSLOT),
   localparam int unsigned PATW     = NSLOT * CMD_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            display_active,
   input  logic [SW-1:0]   slot_idx,
   input  logic [NLAYER-1:0] layer_en,
   input  logic            split_a,
   input  logic            split_b,
   input  logic [PATW-1:0] pat_a_bk0,
   input  logic [PATW-1:0] pat_a_bk1,
   input  logic [PATW-1:0] pat_b_bk0,
   input  logic [PATW-1:0] pat_b_bk1,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic            cpu_half,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic            cpu_wait,
   output logic            slot_ok_a,
   output logic            slot_ok_b,
   output logic            ram_a_en,
   output logic            ram_a_we,
   output logic [AW-1:0]   ram_a_addr,
   output logic [DW-1:0]   ram_a_wdata,
   output logic            ram_b_en,
   output logic            ram_b_we,
   output logic [AW-1:0]   ram_b_addr,
   output logic [DW-1:0]   ram_b_wdata
);
   localparam int unsigned EW     = 1 + AW + DW;
   localparam int unsigned KEYPOS = AW + DW;

   if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (NLAYER < 1 || NLAYER > MAX_LAYERS) begin : g_bad_nlayer
      $error("NLAYER must lie in 1..8");
   end
   if (WB_DEPTH < 1) begin : g_bad_depth
      $error("WB_DEPTH must be at least 1");
   end

   logic [PATW-1:0] pat0_v [2];
   logic [PATW-1:0] pat1_v [2];
   logic [1:0]      split_v, ok_v, en_v, we_v, seen;
   logic [AW-1:0]   addr_v  [2];
   logic [DW-1:0]   wdata_v [2];

   assign pat0_v[0] = pat_a_bk0;
   assign pat1_v[0] = pat_a_bk1;
   assign pat0_v[1] = pat_b_bk0;
   assign pat1_v[1] = pat_b_bk1;
   assign split_v   = {split_b, split_a};

   for (genvar gh = 0; gh < 2; gh++) begin : g_half
      vslot_qualify #(
         .NSLOT    (NSLOT),
         .NLAYER   (NLAYER),
         .SPLIT_CAP(SPLIT_CAP[gh])
      ) i_qualify (
         .clk           (clk),
         .rst_n         (rst_n),
         .display_active(display_active),
         .split_en      (split_v[gh]),
         .layer_en      (layer_en),
         .pat_bk0       (pat0_v[gh]),
         .pat_bk1       (pat1_v[gh]),
         .slot_idx      (slot_idx),
         .slot_ok       (ok_v[gh])
      );
   end

   // write buffer and request decisions
   logic          run, wb_full, wb_empty, drain, rd_go, wr_go;
   logic [EW-1:0] head;
   logic          head_half;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data;

   assign run       = rst_n;
   assign head_half = head[KEYPOS];
   assign head_addr = head[DW +: AW];
   assign head_data = head[DW-1:0];

   assign drain = run && !wb_empty && ok_v[head_half];
   assign rd_go = run && cpu_req && !cpu_we && ok_v[cpu_half] && !seen[cpu_half];
   assign wr_go = run && cpu_req && cpu_we && (!wb_full || drain);
   assign cpu_wait = run && cpu_req && !rd_go && !wr_go;

   vslot_wbuf #(
      .DEPTH (WB_DEPTH),
      .EW    (EW),
      .KEYPOS(KEYPOS)
   ) i_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wr_go),
      .push_data({cpu_half, cpu_addr, cpu_wdata}),
      .pop      (drain),
      .head     (head),
      .full     (wb_full),
      .empty    (wb_empty),
      .key_seen (seen)
   );

   for (genvar gh = 0; gh < 2; gh++) begin : g_strobe
      assign we_v[gh]    = drain && (head_half == 1'(gh));
      assign en_v[gh]    = we_v[gh] || (rd_go && (cpu_half == 1'(gh)));
      assign addr_v[gh]  = we_v[gh] ? head_addr : cpu_addr;
      assign wdata_v[gh] = we_v[gh] ? head_data : '0;

      assert_strobe_in_slot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         en_v[gh] |-> ok_v[gh]);

      assert_read_after_drain_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         en_v[gh] && !we_v[gh] |-> !seen[gh]);
   end

   assign slot_ok_a   = ok_v[0];
   assign slot_ok_b   = ok_v[1];
   assign ram_a_en    = en_v[0];
   assign ram_a_we    = we_v[0];
   assign ram_a_addr  = addr_v[0];
   assign ram_a_wdata = wdata_v[0];
   assign ram_b_en    = en_v[1];
   assign ram_b_we    = we_v[1];
   assign ram_b_addr  = addr_v[1];
   assign ram_b_wdata = wdata_v[1];

   assert_wait_needs_req_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> cpu_req);

   assert_write_room_no_wait_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && !wb_full |-> !cpu_wait);
endmodule

// File: tb/test_vram_slot_arbiter.sv
module test_vram_slot_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] C_CPU  = 4'hC;
   localparam logic [3:0] C_IDLE = 4'hF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        display_active;
   logic [2:0]  slot_idx;
   logic [7:0]  layer_en;
   logic        split_a, split_b;
   logic [31:0] pat_a_bk0, pat_a_bk1, pat_b_bk0, pat_b_bk1;
   logic        cpu_req, cpu_we, cpu_half;
   logic [15:0] cpu_addr;
   logic [31:0] cpu_wdata;
   logic        cpu_wait, slot_ok_a, slot_ok_b;
   logic        ram_a_en, ram_a_we, ram_b_en, ram_b_we;
   logic [15:0] ram_a_addr, ram_b_addr;
   logic [31:0] ram_a_wdata, ram_b_wdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit last_done;

   typedef struct {bit h; logic [15:0] a; logic [31:0] d;} ent_t;
   ent_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vram_slot_arbiter i_vram_slot_arbiter (
      .clk(clk), .rst_n(rst_n), .display_active(display_active), .slot_idx(slot_idx),
      .layer_en(layer_en), .split_a(split_a), .split_b(split_b),
      .pat_a_bk0(pat_a_bk0), .pat_a_bk1(pat_a_bk1), .pat_b_bk0(pat_b_bk0), .pat_b_bk1(pat_b_bk1),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_half(cpu_half), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .slot_ok_a(slot_ok_a), .slot_ok_b(slot_ok_b),
      .ram_a_en(ram_a_en), .ram_a_we(ram_a_we), .ram_a_addr(ram_a_addr), .ram_a_wdata(ram_a_wdata),
      .ram_b_en(ram_b_en), .ram_b_we(ram_b_we), .ram_b_addr(ram_b_addr), .ram_b_wdata(ram_b_wdata)
   );

   function automatic logic [3:0] nib(input logic [31:0] p, input int k);
      return p[k*4 +: 4];
   endfunction

   // reference rule: walk backwards through a run of CPU pairs to its idle pair
   function automatic bit model_ok(input logic [31:0] p0, input logic [31:0] p1,
                                   input logic sp, input int s);
      logic [3:0] c;
      int k;
      if (!display_active) return 1;
      if (!sp) begin
         c = nib(p0, s);
         if (c == C_CPU || c == C_IDLE) return 1;
         if (c < 8) return !layer_en[c[2:0]];
         return 0;
      end
      k = s;
      for (int n = 0; n < 8; n++) begin
         int p;
         if (!(nib(p0, k) == C_CPU && nib(p1, k) == C_CPU)) return 0;
         p = (k + 7) % 8;
         if (nib(p0, p) == C_IDLE && nib(p1, p) == C_IDLE) return 1;
         k = p;
      end
      return 0;
   endfunction

   function automatic string ok_tag(input logic [31:0] p0, input logic sp);
      logic [3:0] c;
      if (!display_active) return "R4";
      if (sp) return "R3";
      c = nib(p0, int'(slot_idx));
      return (c == C_CPU || c == C_IDLE) ? "R1" : "R2";
   endfunction

   task automatic cmp(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_cycle();
      bit okv[2], pend[2], exp_en[2], exp_we[2];
      logic [15:0] exp_ad[2];
      logic [31:0] exp_wd[2];
      bit drain, rd, wr, wt;
      logic        act_en[2], act_we[2];
      logic [15:0] act_ad[2];
      logic [31:0] act_wd[2];
      okv[0] = model_ok(pat_a_bk0, pat_a_bk1, split_a, int'(slot_idx));
      okv[1] = model_ok(pat_b_bk0, pat_b_bk1, split_b, int'(slot_idx));
      pend[0] = 0; pend[1] = 0;
      foreach (q[i]) pend[q[i].h] = 1;
      drain = rst_n && q.size() > 0 && okv[q[0].h];
      rd = rst_n && cpu_req && !cpu_we && okv[cpu_half] && !pend[cpu_half];
      wr = rst_n && cpu_req && cpu_we && (q.size() < 2 || drain);
      wt = rst_n && cpu_req && !rd && !wr;
      for (int h = 0; h < 2; h++) begin
         exp_we[h] = drain && (q[0].h == h);
         exp_en[h] = exp_we[h] || (rd && cpu_half == h);
         exp_ad[h] = exp_we[h] ? q[0].a : cpu_addr;
         exp_wd[h] = exp_we[h] ? q[0].d : 32'h0;
      end
      act_en[0] = ram_a_en; act_we[0] = ram_a_we; act_ad[0] = ram_a_addr; act_wd[0] = ram_a_wdata;
      act_en[1] = ram_b_en; act_we[1] = ram_b_we; act_ad[1] = ram_b_addr; act_wd[1] = ram_b_wdata;
      // R5: qualifiers compared in the same cycle as slot_idx
      cmp(ok_tag(pat_a_bk0, split_a), "slot_ok_a", slot_ok_a, okv[0]);
      cmp(ok_tag(pat_b_bk0, split_b), "slot_ok_b", slot_ok_b, okv[1]);
      cmp(!rst_n ? "R10" : (cpu_we ? "R7" : "R8"), "cpu_wait", cpu_wait, wt);
      for (int h = 0; h < 2; h++) begin
         string tg;
         tg = !rst_n ? "R10" : (exp_we[h] ? "R6" : "R8");
         cmp(tg, h ? "ram_b_en" : "ram_a_en", act_en[h], exp_en[h]);
         cmp(tg, h ? "ram_b_we" : "ram_a_we", act_we[h], exp_we[h]);
         if (exp_en[h]) cmp(tg, h ? "ram_b_addr" : "ram_a_addr", act_ad[h], exp_ad[h]);
         if (exp_we[h]) cmp("R6", h ? "ram_b_wdata" : "ram_a_wdata", act_wd[h], exp_wd[h]);
      end
      cmp("R9", "strobe outside slot A", ram_a_en && !slot_ok_a, 0);
      cmp("R9", "strobe outside slot B", ram_b_en && !slot_ok_b, 0);
      if (!rst_n) q.delete();
      else begin
         if (drain) void'(q.pop_front());
         if (wr) q.push_back('{h: cpu_half, a: cpu_addr, d: cpu_wdata});
      end
      last_done = rd || wr;
   endtask

   task automatic cyc();
      @(negedge clk);
      check_cycle();
      @(posedge clk);
      #1;
      slot_idx = slot_idx + 3'd1;
   endtask

   task automatic cpu_op(input bit we, input bit h, input logic [15:0] a, input logic [31:0] d);
      cpu_req = 1; cpu_we = we; cpu_half = h; cpu_addr = a; cpu_wdata = d;
      for (int n = 0; n < 200; n++) begin
         cyc();
         if (last_done) break;
      end
      cpu_req = 0;
   endtask

   function automatic logic [31:0] rand_pat();
      logic [31:0] p;
      for (int k = 0; k < 8; k++) begin
         case ($urandom_range(0, 6))
            0, 1, 2: p[k*4 +: 4] = C_CPU;
            3, 4:    p[k*4 +: 4] = C_IDLE;
            5:       p[k*4 +: 4] = 4'($urandom_range(0, 7));
            default: p[k*4 +: 4] = 4'($urandom_range(8, 14));
         endcase
      end
      return p;
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      rst_n = 0; display_active = 1; slot_idx = 0; layer_en = 8'h00;
      split_a = 0; split_b = 0;
      pat_a_bk0 = 32'hFFFFFFFF; pat_a_bk1 = 32'hFFFFFFFF;
      pat_b_bk0 = 32'hFFFFFFFF; pat_b_bk1 = 32'hFFFFFFFF;
      cpu_req = 1; cpu_we = 1; cpu_half = 0; cpu_addr = 16'h0; cpu_wdata = 32'h0;
      // R10: request held during reset is neither taken nor stalled
      repeat (3) cyc();
      cpu_req = 0; rst_n = 1;

      // R1, R2: unsplit decoding with layer enables
      pat_a_bk0 = 32'hFC73_09CF; pat_b_bk0 = 32'hE0D1_8BC2;
      layer_en = 8'b1000_1001;
      repeat (8) cyc();
      layer_en = 8'b0111_0110;
      repeat (8) cyc();

      // R3: split runs, mismatched banks, ring of CPU pairs
      split_b = 1;
      pat_b_bk0 = 32'hCCFC_CCCF;
      pat_b_bk1 = 32'hCCCC_FCCF;
      split_a = 1; pat_a_bk0 = 32'hCCCC_CCCC; pat_a_bk1 = 32'hCCCC_CCCC;
      repeat (16) cyc();

      // R4: blanking opens all slots
      display_active = 0;
      repeat (8) cyc();
      display_active = 1;

      // R6, R7, R8: half A open only at slot 5, half B always open
      split_a = 0; split_b = 0; layer_en = 8'hFF;
      pat_a_bk0 = 32'h00C0_0000; pat_b_bk0 = 32'hFFFF_FFFF;
      slot_idx = 0;
      cpu_op(1, 0, 16'h0101, 32'hAAAA_0001);
      cpu_op(1, 0, 16'h0102, 32'hAAAA_0002);
      cpu_op(1, 0, 16'h0103, 32'hAAAA_0003);
      cpu_op(0, 0, 16'h0104, 32'h0);
      cpu_op(1, 0, 16'h0105, 32'hAAAA_0005);
      cpu_op(1, 1, 16'h0201, 32'hBBBB_0001);
      cpu_op(0, 1, 16'h0202, 32'h0);
      repeat (16) cyc();

      // mixed random traffic
      for (int blk = 0; blk < 100; blk++) begin
         pat_a_bk0 = rand_pat(); pat_a_bk1 = rand_pat();
         pat_b_bk0 = rand_pat(); pat_b_bk1 = rand_pat();
         split_a = 1'($urandom_range(0, 1)); split_b = 1'($urandom_range(0, 1));
         layer_en = 8'($urandom_range(0, 255));
         display_active = ($urandom_range(0, 5) != 0);
         for (int n = 0; n < 32; n++) begin
            cpu_req = 1'($urandom_range(0, 1)); cpu_we = 1'($urandom_range(0, 1));
            cpu_half = 1'($urandom_range(0, 1));
            cpu_addr = 16'($urandom_range(0, 65535)); cpu_wdata = $urandom();
            cyc();
         end
      end
      cpu_req = 0;
      repeat (4) cyc();
      finish_run();
   end
endmodule